// File: doc/BRIEF.md
# Edge-Armed Pulse Counter with Enforced Dead Time

This block counts detector pulses from a comparator output. The comparator level first passes through a synchronizer. A pulse is counted only when the synchronized level goes from low to high while the block is armed. When a pulse is counted, the block increments a saturating integral counter. In the same cycle it raises a hold line that freezes an external sample-and-hold, and it disarms itself for a programmable dead time given in whole microseconds.

When the dead time expires the block re-arms. A comparator level that is still high at that moment is not counted, because counting needs a new low-to-high transition. As a result the effective blocking can last longer than the programmed window, and a flag reports that this has happened. None of the interfaces carries a data stream. Every pin is a plain level that is updated every clock, so no valid/ready handshake and no back-pressure apply.

Top module: `pulse_dead_counter`

## Requirements
- R1: A count is taken only on a low-to-high transition of the synchronized comparator level. Falling edges and steady levels never count. A new level on `comp_i` first reaches `count_o` right after the third rising clock edge that samples it.
- R2: An accepted transition increments `count_o` by one, and `hold_o` rises in the same cycle.
- R3: After an accepted transition, `hold_o` and `busy_o` stay high for exactly L clock cycles, where L = `dead_us_i` × CYC_PER_US. Transitions during those cycles are not counted.
- R4: A dead-time setting of 0 still blocks for exactly one clock cycle (L = 1).
- R5: If the synchronized level is high in the cycle the block re-arms, that level is not counted. Counting resumes only after the level falls and rises again. `stretch_o` is high from the re-arm until the synchronized level is seen low.
- R6: `count_o` saturates at its all-ones value instead of wrapping.
- R7: While reset is applied, `count_o` is 0 and `hold_o`, `busy_o` and `stretch_o` are 0. The block leaves reset armed, but a comparator that is already high then is not counted until it falls and rises again.
- R8: `dead_us_i` is sampled only on the accepted transition. Changes to it while blocked do not alter the current window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| comp_i | input | 1 | Asynchronous comparator level |
| dead_us_i | input | DT_W | Enforced dead time in microseconds |
| hold_o | output | 1 | Freezes the external sample-and-hold while high |
| count_o | output | CNT_W | Saturating integral pulse count |
| busy_o | output | 1 | High from an accepted pulse until re-armed |
| stretch_o | output | 1 | Re-arm found the comparator still high; cleared when it drops |

## Verification
The critical coincidence is a re-arm and a rising comparator level in the same cycle. The rising level must then be ignored and `stretch_o` raised, rather than the level being counted. The bench provokes this directly by holding the comparator high across the end of the window. It also provokes it at random by toggling the input often while using short dead times. Both are judged against a cycle model in the bench that applies the timing in R1 to R5. A narrow-counter instance in the bench runs on the same stimulus and exercises the collision of an accepted pulse with counter saturation.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  typedef enum logic {
    ARM_READY   = 1'b0,
    ARM_BLOCKED = 1'b1
  } arm_e;

endpackage

// File: rtl/pdc_sync.sv
module pdc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= RST_VAL;
          else         chain_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= RST_VAL;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pdc_dead_timer.sv
module pdc_dead_timer #(
  parameter int TW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] len_i,
  output logic          expire_o
);

  logic [TW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              left_q <= '0;
    else if (load_i)          left_q <= len_i;
    else if (left_q != '0)    left_q <= left_q - TW'(1);
  end

  assign expire_o = (left_q == TW'(1));

  // R3
  load_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> left_q == '0);

  // R4
  min_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> left_q != '0);

endmodule

// File: rtl/pdc_sat_counter.sv
module pdc_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (inc_i && cnt_q != TOP) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  // R2
  step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_q != TOP) |=> cnt_q == $past(cnt_q) + W'(1));

  // R6
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == TOP |=> cnt_q == TOP);

endmodule

// File: rtl/pulse_dead_counter.sv
module pulse_dead_counter
  import pdc_pkg::*;
#(
  parameter int CYC_PER_US  = 50,
  parameter int DT_W        = 8,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             comp_i,
  input  logic [DT_W-1:0]  dead_us_i,
  output logic             hold_o,
  output logic [CNT_W-1:0] count_o,
  output logic             busy_o,
  output logic             stretch_o
);

  localparam int TW = DT_W + $clog2(CYC_PER_US + 1);

  logic          lvl;
  logic          lvl_prev_q;
  logic          rise;
  logic          accept;
  logic          expire;
  logic [TW-1:0] win_len;
  arm_e          arm_q;
  logic          stretch_q;

  // Synchronizer resets high so a level already present at reset needs a fresh edge.
  pdc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (comp_i),
    .q_o    (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_prev_q <= 1'b1;
    else         lvl_prev_q <= lvl;
  end

  assign rise   = lvl & ~lvl_prev_q;
  assign accept = (arm_q == ARM_READY) && rise;

  always_comb begin
    if (dead_us_i == '0) win_len = TW'(1);
    else                 win_len = TW'(dead_us_i) * TW'(CYC_PER_US);
  end

  pdc_dead_timer #(.TW(TW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .len_i    (win_len),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= ARM_READY;
    end else begin
      case (arm_q)
        ARM_READY:   if (accept) arm_q <= ARM_BLOCKED;
        ARM_BLOCKED: if (expire) arm_q <= ARM_READY;
        default:     arm_q <= ARM_READY;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         stretch_q <= 1'b0;
    else if (arm_q == ARM_BLOCKED && expire) stretch_q <= lvl;
    else                                 stretch_q <= stretch_q & lvl;
  end

  pdc_sat_counter #(.W(CNT_W)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (accept),
    .cnt_o  (count_o)
  );

  assign hold_o    = (arm_q == ARM_BLOCKED);
  assign busy_o    = (arm_q == ARM_BLOCKED);
  assign stretch_o = stretch_q;

  // R3
  frozen_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(count_o));

  // R2
  hold_with_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> (count_o != $past(count_o) || $past(count_o) == '1));

  // R5
  stretch_at_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stretch_o) |-> $fell(busy_o));

  // R5
  stretch_needs_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stretch_o |-> $past(lvl));

endmodule

// File: tb/test_pulse_dead_counter.sv
module test_pulse_dead_counter;

  localparam int CPU  = 50;
  localparam int DT_W = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            comp = 1'b0;
  logic [DT_W-1:0] dead = '0;
  logic            hold, busy, stretch;
  logic [31:0]     count;
  logic [3:0]      sat_count;
  logic            s_hold, s_busy, s_stretch;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pulse_dead_counter #(.CYC_PER_US(CPU), .DT_W(DT_W)) i_pulse_dead_counter (
    .clk_i(clk), .rst_ni(rst_n), .comp_i(comp), .dead_us_i(dead),
    .hold_o(hold), .count_o(count), .busy_o(busy), .stretch_o(stretch));

  pulse_dead_counter #(.CYC_PER_US(CPU), .DT_W(DT_W), .CNT_W(4)) i_sat (
    .clk_i(clk), .rst_ni(rst_n), .comp_i(comp), .dead_us_i(dead),
    .hold_o(s_hold), .count_o(sat_count), .busy_o(s_busy), .stretch_o(s_stretch));

  // cycle model state
  bit m_f1 = 1, m_s = 1, m_p = 1, m_armed = 1, m_str = 0;
  int m_left = 0;
  longint m_cnt = 0;
  longint prev_count = 0;
  bit prev_hold = 0;
  int busy_run = 0, last_run = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int win(logic [DT_W-1:0] d);
    return (d == 0) ? 1 : int'(d) * CPU;
  endfunction

  task automatic model_edge();
    bit rise, acc, exp_now;
    if (!rst_n) begin
      m_f1 = 1; m_s = 1; m_p = 1; m_armed = 1; m_str = 0; m_left = 0; m_cnt = 0;
      return;
    end
    rise    = m_s & ~m_p;
    acc     = m_armed & rise;
    exp_now = !m_armed && m_left == 1;
    m_str   = exp_now ? m_s : (m_str & m_s);
    if (acc) begin
      m_armed = 0; m_left = win(dead); m_cnt++;
    end else if (!m_armed) begin
      if (m_left == 1) m_armed = 1;
      m_left--;
    end
    m_p = m_s; m_s = m_f1; m_f1 = comp;
  endtask

  task automatic compare();
    if (!rst_n) return;
    chk(count == 32'(m_cnt), "R1", "count", count, m_cnt);
    chk(hold == !m_armed, "R3", "hold", hold, !m_armed);
    chk(busy == !m_armed, "R3", "busy", busy, !m_armed);
    chk(stretch == m_str, "R5", "stretch", stretch, m_str);
    chk(longint'(sat_count) == ((m_cnt > 15) ? 15 : m_cnt), "R6", "sat count",
        sat_count, (m_cnt > 15) ? 15 : m_cnt);
    if (longint'(count) != prev_count)
      chk(hold && !prev_hold && longint'(count) == prev_count + 1, "R2",
          "hold rise with increment", hold, 1);
    if (busy) busy_run++;
    else if (busy_run != 0) begin last_run = busy_run; busy_run = 0; end
    prev_count = count;
    prev_hold  = hold;
  endtask

  // called at negedge: drive, take an edge, sample at next negedge
  task automatic step(bit c);
    comp = c;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic hold_lvl(bit c, int n);
    for (int i = 0; i < n; i++) step(c);
  endtask

  initial begin
    longint base;
    bit lvl;
    void'($urandom(32'd4242));
    comp = 1'b1;
    dead = 8'd1;
    repeat (3) @(negedge clk);
    chk(count == 0 && !hold && !busy && !stretch, "R7", "reset outputs", count, 0);
    rst_n = 1'b1;
    hold_lvl(1, 10);
    chk(count == 0, "R7", "high at reset not counted", count, 0);
    hold_lvl(0, 4);
    hold_lvl(1, 3);
    chk(count == 1 && hold, "R2", "fresh edge counted", count, 1);
    hold_lvl(1, 60);
    chk(count == 1 && stretch, "R5", "level high at rearm", count, 1);
    chk(last_run == CPU, "R3", "window length 1us", last_run, CPU);
    hold_lvl(0, 4);
    chk(!stretch, "R5", "stretch clears on low", stretch, 0);
    hold_lvl(1, 4);
    chk(count == 2, "R5", "count resumes after new edge", count, 2);
    hold_lvl(0, 10);
    chk(count == 2, "R1", "falling edge ignored", count, 2);
    // edges during window ignored
    hold_lvl(0, 60);
    base = count;
    hold_lvl(1, 3);
    for (int i = 0; i < 10; i++) begin hold_lvl(0, 2); hold_lvl(1, 2); end
    chk(longint'(count) == base + 1, "R3", "edges in window ignored", count, base + 1);
    hold_lvl(0, 60);
    // zero setting: one cycle window
    dead = 8'd0;
    hold_lvl(1, 3);
    hold_lvl(0, 4);
    chk(last_run == 1, "R4", "zero setting window", last_run, 1);
    // back-to-back with zero setting
    base = count;
    hold_lvl(1, 1); hold_lvl(0, 2); hold_lvl(1, 1); hold_lvl(0, 6);
    chk(longint'(count) == base + 2, "R4", "quick pulses counted", count, base + 2);
    // setting changed while busy
    dead = 8'd1;
    hold_lvl(1, 3);
    dead = 8'd3;
    hold_lvl(0, 60);
    chk(last_run == CPU, "R8", "setting latched at accept", last_run, CPU);
    hold_lvl(0, 160);
    // random phase
    lvl = 0;
    for (int i = 0; i < 30000; i++) begin
      if ($urandom % 8 == 0) lvl = ~lvl;
      if ($urandom % 128 == 0) dead = DT_W'($urandom % 4);
      step(lvl);
    end
    chk(sat_count == 4'hF, "R6", "narrow counter saturated", sat_count, 15);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule